// File: doc/BRIEF.md
# Single-Bus Register Swap Controller

This block exchanges the contents of two data registers by routing every move over one shared bus. Because only one value can travel on that bus in a clock cycle, a third register serves as a scratch holder. The swap takes three transfers. A small Moore state machine steps through them, one per cycle. In each step it picks which register drives the bus and which single register captures the bus value.

The machine rests in an idle state until the start input is seen high at a clock edge. It then performs three steps. First the second register is parked in the scratch register. Next the first register is copied into the second. Last the scratch value is written back into the first. After the third step the machine returns to idle without condition. A parallel load path lets the surrounding logic preset both data registers, but only while the machine is idle. A one-cycle done pulse marks the final write-back.

Top module: `swap_bus_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all three registers and leaves the controller idle: ld_en = 3'b000, bus_sel = 2'b00, done = 0.
- R2: In idle with start high at an edge, the next cycle drives bus_sel = 2'b01 (second register) and ld_en = 3'b100 (scratch load only). ld_en bit 0 loads reg1, bit 1 loads reg2 and bit 2 loads scratch. bus_sel codes are 00 = reg1, 01 = reg2 and 10 = scratch.
- R3: The cycle after a scratch load drives bus_sel = 2'b00 with ld_en = 3'b010, whatever start does.
- R4: The cycle after a reg2 load drives bus_sel = 2'b10 with ld_en = 3'b001 and done = 1.
- R5: After the write-back cycle the controller is idle (ld_en = 3'b000), even when start is held high.
- R6: At most one load enable is high in any cycle.
- R7: In idle with start low, the controller stays idle and all three registers hold their values.
- R8: In the scratch-load step, the scratch register captures the value reg2 held in that cycle.
- R9: Three edges after start is sampled in idle, reg1 and reg2 hold each other's former values and scratch holds the former reg2.
- R10: In idle, load high writes load_r1 into reg1 and load_r2 into reg2 at the edge. During a swap, load has no effect.
- R11: done is high for exactly one cycle per swap.
- R12: Holding start high runs swaps back to back, one every four cycles, so two swaps restore the original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a swap when sampled high in idle |
| load | input | 1 | Presets reg1 and reg2 while idle |
| load_r1 | input | WIDTH | Preset value for reg1 |
| load_r2 | input | WIDTH | Preset value for reg2 |
| r1_q | output | WIDTH | reg1 contents |
| r2_q | output | WIDTH | reg2 contents |
| r3_q | output | WIDTH | Scratch register contents |
| bus_sel | output | 2 | Bus source: 00 reg1, 01 reg2, 10 scratch |
| ld_en | output | 3 | One-hot load enables: bit0 reg1, bit1 reg2, bit2 scratch |
| done | output | 1 | High during the write-back step |

## Verification
The bench watches the exact select and enable value of every step. A wrong ordering shows up as a clobbered value, for example reg2 overwritten before it is parked. The bench drives load during a swap: a design that honours it would end with the preset values in place of swapped ones. It holds start across two swaps and also puts it high in the middle of a swap. If the write-back state waited on start, or if start restarted the sequence early, the done pulses would be misplaced and reg1 and reg2 would not return to their original values. A load issued on the same edge as start checks that the scratch register takes the freshly loaded reg2.

// File: rtl/swap_bus_ctrl.sv
module swap_bus_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             load,
  input  logic [WIDTH-1:0] load_r1,
  input  logic [WIDTH-1:0] load_r2,
  output logic [WIDTH-1:0] r1_q,
  output logic [WIDTH-1:0] r2_q,
  output logic [WIDTH-1:0] r3_q,
  output logic [1:0]       bus_sel,
  output logic [2:0]       ld_en,
  output logic             done
);

  logic y2, y1;
  logic y2_nx, y1_nx;
  logic idle;
  logic [WIDTH-1:0] bus;

  assign y2_nx = y2 ^ y1;
  assign y1_nx = (start & ~y2 & ~y1) | (y2 & ~y1);

  always_ff @(posedge clk) begin
    if (rst) begin
      y2 <= 1'b0;
      y1 <= 1'b0;
    end else begin
      y2 <= y2_nx;
      y1 <= y1_nx;
    end
  end

  assign idle     = ~y2 & ~y1;
  assign ld_en[2] = ~y2 &  y1;
  assign ld_en[1] =  y2 & ~y1;
  assign ld_en[0] =  y2 &  y1;
  assign done     = ld_en[0];
  assign bus_sel  = {y2 & y1, ~y2 & y1};

  always_comb begin
    case (bus_sel)
      2'b01:   bus = r2_q;
      2'b10:   bus = r3_q;
      default: bus = r1_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else begin
      if (idle && load)  r1_q <= load_r1;
      else if (ld_en[0]) r1_q <= bus;
      if (idle && load)  r2_q <= load_r2;
      else if (ld_en[1]) r2_q <= bus;
      if (ld_en[2])      r3_q <= bus;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ld_en == 3'b000 && bus_sel == 2'b00 && !done && r3_q == '0));

  // R2
  start_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en == 3'b000 && start) |=> (ld_en == 3'b100 && bus_sel == 2'b01));

  // R3
  second_step_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en[2] |=> (ld_en == 3'b010 && bus_sel == 2'b00));

  // R4
  third_step_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en[1] |=> (ld_en == 3'b001 && bus_sel == 2'b10 && done));

  // R5
  back_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en[0] |=> (ld_en == 3'b000));

  // R6
  one_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_en));

  // R7
  stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en == 3'b000 && !start) |=> (ld_en == 3'b000 && $stable(r3_q)));

  // R8
  park_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en[2] |=> (r3_q == $past(r2_q)));

  // R10
  load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en[2] || ld_en[0]) |=> $stable(r2_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/test_swap_bus_ctrl.sv
module test_swap_bus_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, start, load;
  logic [W-1:0] load_r1, load_r2;
  logic [W-1:0] r1_q, r2_q, r3_q;
  logic [1:0]   bus_sel;
  logic [2:0]   ld_en;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  swap_bus_ctrl #(.WIDTH(W)) i_swap_bus_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load),
    .load_r1(load_r1), .load_r2(load_r2),
    .r1_q(r1_q), .r2_q(r2_q), .r3_q(r3_q),
    .bus_sel(bus_sel), .ld_en(ld_en), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preset(logic [W-1:0] a, logic [W-1:0] b);
    load = 1'b1; load_r1 = a; load_r2 = b;
    tick();
    load = 1'b0;
    chk("R10 preset r1", r1_q, a);
    chk("R10 preset r2", r2_q, b);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; load = 1'b0; load_r1 = '0; load_r2 = '0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 ld_en", ld_en, 3'b000);
    chk("R1 bus_sel", bus_sel, 2'b00);
    chk("R1 done", done, 1'b0);
    chk("R1 r1", r1_q, 0);
    chk("R1 r2", r2_q, 0);
    chk("R1 r3", r3_q, 0);
  endtask

  task automatic t_single_swap(logic [W-1:0] a, logic [W-1:0] b);
    preset(a, b);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R2 ld_en", ld_en, 3'b100);
    chk("R2 bus_sel", bus_sel, 2'b01);
    chk("R11 done low in step1", done, 1'b0);
    tick();
    chk("R8 scratch", r3_q, b);
    chk("R3 ld_en", ld_en, 3'b010);
    chk("R3 bus_sel", bus_sel, 2'b00);
    tick();
    chk("R9 r2 mid", r2_q, a);
    chk("R4 ld_en", ld_en, 3'b001);
    chk("R4 bus_sel", bus_sel, 2'b10);
    chk("R4 done", done, 1'b1);
    tick();
    chk("R9 r1", r1_q, b);
    chk("R9 r2", r2_q, a);
    chk("R9 r3", r3_q, b);
    chk("R5 idle", ld_en, 3'b000);
    chk("R11 done pulse ends", done, 1'b0);
  endtask

  task automatic t_idle_hold();
    logic [W-1:0] s1, s2, s3;
    s1 = r1_q; s2 = r2_q; s3 = r3_q;
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7 ld_en", ld_en, 3'b000);
    end
    chk("R7 r1", r1_q, s1);
    chk("R7 r2", r2_q, s2);
    chk("R7 r3", r3_q, s3);
  endtask

  task automatic t_load_ignored(logic [W-1:0] a, logic [W-1:0] b);
    preset(a, b);
    start = 1'b1;
    tick();
    start = 1'b0;
    load = 1'b1; load_r1 = 8'hEE; load_r2 = 8'hDD;
    tick();
    start = 1'b1;
    tick();
    tick();
    load = 1'b0; start = 1'b0;
    chk("R10 ignored r1", r1_q, b);
    chk("R10 ignored r2", r2_q, a);
    chk("R5 no restart from mid-swap start", ld_en, 3'b000);
  endtask

  task automatic t_held_start(logic [W-1:0] a, logic [W-1:0] b);
    int dones = 0;
    preset(a, b);
    start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (done) dones++;
      if (i == 3) begin
        chk("R12 first swap r1", r1_q, b);
        chk("R5 idle with start held", ld_en, 3'b000);
      end
    end
    start = 1'b0;
    chk("R12 restored r1", r1_q, a);
    chk("R12 restored r2", r2_q, b);
    chk("R11 two done pulses", dones, 2);
  endtask

  task automatic t_load_with_start(logic [W-1:0] a, logic [W-1:0] b);
    load = 1'b1; load_r1 = a; load_r2 = b; start = 1'b1;
    tick();
    load = 1'b0; start = 1'b0;
    chk("R2 start alongside load", ld_en, 3'b100);
    tick();
    chk("R8 scratch gets fresh r2", r3_q, b);
    tick(); tick();
    chk("R9 r1 after load+start", r1_q, b);
    chk("R9 r2 after load+start", r2_q, a);
  endtask

  initial begin
    t_reset();
    t_single_swap(8'h3C, 8'hA5);
    t_idle_hold();
    t_single_swap(8'h00, 8'hFF);
    t_load_ignored(8'h12, 8'h34);
    t_held_start(8'h5A, 8'hC3);
    t_load_with_start(8'h77, 8'h81);
    t_idle_hold();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400us;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule